// File: doc/BRIEF.md
# Octet-Aligned HDLC Receive Destuffer

This block takes a byte stream with octet-aligned HDLC framing and rebuilds the packets in it. It checks every accepted byte for the flag value 7Eh. Flags mark packet boundaries and are dropped, and so are the flags that fill the gap between packets. A stuffed byte arrives as the escape value 7Dh followed by the original byte XORed with 20h; the block removes the escape and restores the original byte. If an escape is followed by a flag inside a packet, the block treats the pair as an abort. It marks the packet as aborted, increments a counter and then discards input until it sees the next flag.

The recovered bytes leave the block one at a time. Each carries start, end and abort markers. The block always holds one recovered byte back, so it can put the end marker on the true last byte when the closing flag arrives. A clear-channel input turns off all framing work, and every byte is then forwarded unchanged.

Top module: `hdlc_octet_rx`

## Requirements
- R1: After reset, out_valid is low and abort_count is zero. The receiver is hunting: every byte before the first 7Eh, 7Dh included, is discarded without output.
- R2: Non-flag bytes between two flags are output in order. out_sop is set on the first byte and out_eop on the last; a one-byte packet has both set. A byte appears on the output in the cycle after the next data byte or the closing flag is accepted.
- R3: Consecutive flags with no data between them produce no output. A single flag closes one packet and also opens the next.
- R4: Inside a packet, a 7Dh byte is removed and the byte after it is output XORed with 20h. So 7Dh 5Eh yields 7Eh and 7Dh 5Dh yields 7Dh.
- R5: Inside a packet, 7Dh followed by 7Eh is an abort. The last held byte is output with out_eop and out_abort both set, and abort_count increments by one. Bytes after the abort are discarded until a 7Eh is seen, and that 7Eh opens a new packet.
- R6: An abort in a packet that has no data byte yet increments abort_count and produces no output.
- R7: abort_count saturates at its all-ones value. With the default 8-bit width this is 255.
- R8: While bypass is high, every accepted byte, 7Eh and 7Dh included, appears on out_data one cycle later with out_sop, out_eop and out_abort low. abort_count does not change.
- R9: Raising bypass discards any byte held back from an open packet. After bypass is lowered, the receiver hunts for a flag again.
- R10: Cycles with in_valid low change neither the output stream nor abort_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_data holds a byte this cycle |
| in_data | input | 8 | Received byte |
| bypass | input | 1 | Clear-channel mode: framing work disabled |
| out_valid | output | 1 | Output byte is present |
| out_data | output | 8 | Recovered byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_abort | output | 1 | Packet ended by an abort |
| abort_count | output | CNT_W | Saturating count of aborts |

## Verification
The hardest state to reach from the ports is a saturated abort counter, because every abort must be built from a complete flag and escape sequence. The stimulus repeats the three-byte pattern 7Eh 7Dh 7Eh well past 255 times: each flag opens a packet and the escape–flag pair right after it aborts that packet. The bench reads the count just below the limit and again after the limit has been passed. Dropping a held byte when bypass rises is reached by parking a byte in the holding register and then switching modes during an idle cycle.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and types for the octet-aligned HDLC receiver.
// Assumes 8-bit octets; the framing values are fixed by the line format.
package hdlc_rx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
    localparam logic [BYTE_W-1:0] ESC_OCTET  = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_MASK   = 8'h20;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_OPEN = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              abort;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;
endpackage

// File: rtl/hdlc_rx_classify.sv
// Byte classifier: flags the two framing values in the incoming byte.
// Purely combinational; assumes the caller qualifies its outputs with valid.
module hdlc_rx_classify
    import hdlc_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              is_flag,
    output logic              is_esc
);
    // Compare against the framing constants.
    always_comb begin
        is_flag = (byte_in == FLAG_OCTET);
        is_esc  = (byte_in == ESC_OCTET);
    end
endmodule

// File: rtl/hdlc_rx_delin.sv
// Delineation and destuffing state machine.
// Emits one-cycle events (data byte, packet close, abort) for the hold stage.
// Assumes fill between packets consists only of flags; pass_en forces hunting.
module hdlc_rx_delin
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              is_flag,
    input  logic              is_esc,
    output logic              ev_data,
    output logic [BYTE_W-1:0] ev_byte,
    output logic              ev_close,
    output logic              ev_abort
);
    rx_state_e state_q, state_d;
    logic      esc_q, esc_d;

    // Next-state and event decode for one accepted byte.
    always_comb begin
        state_d  = state_q;
        esc_d    = esc_q;
        ev_data  = 1'b0;
        ev_byte  = in_data;
        ev_close = 1'b0;
        ev_abort = 1'b0;
        if (pass_en) begin
            state_d = RX_HUNT;
            esc_d   = 1'b0;
        end else if (in_valid) begin
            case (state_q)
                RX_HUNT: begin
                    if (is_flag) state_d = RX_OPEN;
                end
                RX_OPEN: begin
                    if (esc_q) begin
                        esc_d = 1'b0;
                        if (is_flag) begin
                            ev_abort = 1'b1;
                            state_d  = RX_HUNT;
                        end else begin
                            ev_data = 1'b1;
                            ev_byte = in_data ^ ESC_MASK;
                        end
                    end else if (is_flag) begin
                        ev_close = 1'b1;
                    end else if (is_esc) begin
                        esc_d = 1'b1;
                    end else begin
                        ev_data = 1'b1;
                    end
                end
                default: state_d = RX_HUNT;
            endcase
        end
    end

    // State and escape-pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            esc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            esc_q   <= esc_d;
        end
    end
endmodule

// File: rtl/hdlc_rx_hold.sv
// One-byte hold stage and output register.
// Keeps the latest recovered byte back so the closing flag or abort can mark
// it as last. In pass mode it forwards raw bytes and drops any held byte.
module hdlc_rx_hold
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              ev_data,
    input  logic [BYTE_W-1:0] ev_byte,
    input  logic              ev_close,
    input  logic              ev_abort,
    output logic              o_valid,
    output rx_beat_t          o_beat
);
    logic              hold_v;
    logic              hold_sop;
    logic [BYTE_W-1:0] hold_d;

    // Advance the hold register and drive the registered output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_beat   <= '0;
            hold_v   <= 1'b0;
            hold_sop <= 1'b0;
            hold_d   <= '0;
        end else begin
            o_valid <= 1'b0;
            o_beat  <= '0;
            if (pass_en) begin
                hold_v <= 1'b0;
                if (in_valid) begin
                    o_valid     <= 1'b1;
                    o_beat.data <= in_data;
                end
            end else if (ev_data) begin
                if (hold_v) begin
                    o_valid <= 1'b1;
                    o_beat  <= '{sop: hold_sop, eop: 1'b0, abort: 1'b0, data: hold_d};
                end
                hold_d   <= ev_byte;
                hold_sop <= !hold_v;
                hold_v   <= 1'b1;
            end else if (ev_close || ev_abort) begin
                if (hold_v) begin
                    o_valid <= 1'b1;
                    o_beat  <= '{sop: hold_sop, eop: 1'b1, abort: ev_abort, data: hold_d};
                end
                hold_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_abort_ctr.sv
// Abort event counter. SATURATE picks a sticking counter or a wrapping one.
module hdlc_rx_abort_ctr #(
    parameter int CNT_W    = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    generate
        if (SATURATE) begin : g_sat
            // Count up, sticking at the maximum.
            always_ff @(posedge clk) begin
                if (!rst_n)                       count <= '0;
                else if (inc && count != CNT_MAX) count <= count + 1'b1;
            end
        end else begin : g_wrap
            // Count up with wrap-around.
            always_ff @(posedge clk) begin
                if (!rst_n)   count <= '0;
                else if (inc) count <= count + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/hdlc_octet_rx.sv
// Top of the octet-aligned HDLC receiver: classify, delineate and destuff,
// hold one byte for end marking, and count aborts. bypass selects clear channel.
module hdlc_octet_rx #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             bypass,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_abort,
    output logic [CNT_W-1:0] abort_count
);
    import hdlc_rx_pkg::*;

    logic              is_flag, is_esc;
    logic              ev_data, ev_close, ev_abort;
    logic [BYTE_W-1:0] ev_byte;
    rx_beat_t          beat;

    hdlc_rx_classify u_cls (
        .byte_in (in_data),
        .is_flag (is_flag),
        .is_esc  (is_esc)
    );

    hdlc_rx_delin u_delin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_en  (bypass),
        .in_valid (in_valid),
        .in_data  (in_data),
        .is_flag  (is_flag),
        .is_esc   (is_esc),
        .ev_data  (ev_data),
        .ev_byte  (ev_byte),
        .ev_close (ev_close),
        .ev_abort (ev_abort)
    );

    hdlc_rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_en  (bypass),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ev_data  (ev_data),
        .ev_byte  (ev_byte),
        .ev_close (ev_close),
        .ev_abort (ev_abort),
        .o_valid  (out_valid),
        .o_beat   (beat)
    );

    hdlc_rx_abort_ctr #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_abort),
        .count (abort_count)
    );

    // Unpack the output beat onto the ports.
    always_comb begin
        out_data  = beat.data;
        out_sop   = beat.sop;
        out_eop   = beat.eop;
        out_abort = beat.abort;
    end
endmodule

// File: rtl/hdlc_octet_rx_chk.sv
// Property checker for hdlc_octet_rx, attached by bind below.
module hdlc_octet_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             bypass,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_abort,
    input logic [CNT_W-1:0] abort_count
);
    p_markers_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sop && !out_eop && !out_abort));

    p_abort_is_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> (out_valid && out_eop));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (abort_count == $past(abort_count) ||
                  abort_count == $past(abort_count) + 1'b1));

    p_count_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_count == {CNT_W{1'b1}}) |=> (abort_count == {CNT_W{1'b1}}));

    p_pass_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && in_valid) |=> (out_valid && out_data == $past(in_data) &&
                                  !out_sop && !out_eop && !out_abort));

    p_pass_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> $stable(abort_count));

    p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(abort_count));
endmodule

bind hdlc_octet_rx hdlc_octet_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .bypass      (bypass),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_abort   (out_abort),
    .abort_count (abort_count)
);

// File: tb/hdlc_octet_rx_tb_top.sv
// Self-checking bench for hdlc_octet_rx: a vector table, then directed tests.
module hdlc_octet_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int N_STIM     = 28;
    localparam int N_EXP      = 8;

    // Input stream for the table walk (normal mode).
    localparam logic [7:0] STIM [N_STIM] = '{
        8'h11, 8'h7D, 8'h7E, 8'h7E, 8'hA1, 8'hA2, 8'h7E,
        8'hB1, 8'h7D, 8'h5E, 8'h7D, 8'h5D, 8'h7E,
        8'h7E, 8'hC1, 8'h7D, 8'h7E, 8'h55, 8'h7D, 8'h7E,
        8'hD1, 8'h7E, 8'h7E, 8'h7D, 8'h7E, 8'h7E, 8'hE1, 8'h7E
    };
    // Expected beats {sop, eop, abort, data}.
    localparam logic [10:0] EXP [N_EXP] = '{
        {3'b100, 8'hA1}, {3'b010, 8'hA2},
        {3'b100, 8'hB1}, {3'b000, 8'h7E}, {3'b010, 8'h7D},
        {3'b111, 8'hC1}, {3'b110, 8'hD1}, {3'b110, 8'hE1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             bypass = 1'b0;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_sop, out_eop, out_abort;
    logic [CNT_W-1:0] abort_count;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cap_n = 0;
    logic [10:0] cap [0:1023];
    bit          done = 1'b0;

    hdlc_octet_rx #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .bypass(bypass), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
        .abort_count(abort_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Capture every output beat away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 1024) begin
            cap[cap_n] = {out_sop, out_eop, out_abort, out_data};
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 abort_count after reset", abort_count, 0);
        rst_n = 1'b1;

        // Table walk with idle gaps (R10) between some bytes.
        for (int i = 0; i < N_STIM; i++) begin
            send(STIM[i]);
            if (i % 3 == 1) idle(1);
        end
        idle(3);
        // R1..R6, R10: output stream matches the table exactly
        check("R6 R10 beat count", cap_n, N_EXP);
        for (int i = 0; i < N_EXP; i++)
            check($sformatf("R2 R3 R4 R5 beat %0d", i), cap[i], EXP[i]);
        check("R5 R6 abort_count after table", abort_count, 2);

        // R8: clear-channel forwarding
        bypass = 1'b1;
        base = cap_n;
        send(8'h7E); send(8'h7D); send(8'h7E); send(8'h41);
        idle(3);
        check("R8 bypass beat count", cap_n - base, 4);
        check("R8 bypass flag raw", cap[base], {3'b000, 8'h7E});
        check("R8 bypass escape raw", cap[base+1], {3'b000, 8'h7D});
        check("R8 bypass last byte", cap[base+3], {3'b000, 8'h41});
        check("R8 abort_count frozen", abort_count, 2);

        // R9: held byte dropped on entering bypass; hunt after leaving
        @(negedge clk);
        bypass = 1'b0;
        base = cap_n;
        send(8'h7E); send(8'h99);
        @(negedge clk);
        in_valid = 1'b0;
        bypass = 1'b1;
        @(negedge clk);
        bypass = 1'b0;
        send(8'h33); send(8'h7E); send(8'h44); send(8'h7E);
        idle(3);
        check("R9 beats after mode toggle", cap_n - base, 1);
        check("R9 only new packet", cap[base], {3'b110, 8'h44});

        // R7: saturation of the abort counter
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        base = cap_n;
        for (int i = 0; i < 254; i++) begin
            send(8'h7E); send(8'h7D); send(8'h7E);
        end
        idle(2);
        check("R7 count below limit", abort_count, 254);
        for (int i = 0; i < 6; i++) begin
            send(8'h7E); send(8'h7D); send(8'h7E);
        end
        idle(2);
        check("R7 count saturated", abort_count, 255);
        check("R6 empty aborts give no beats", cap_n - base, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule